// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block sits between a group of peripheral interrupt request lines and a small 16-bit processor core. At each instruction boundary it decides whether a request may be taken. A maskable source qualifies when its pending flag, its own enable and the global enable bit of the status word are all set. A non-maskable request needs only its own enable. When several sources qualify together, the block picks the winner by fixed priority.

Once a request is taken, the block runs a fixed five-state entry sequence while the core stalls. The sequence does these steps in order:
- write the address of the next instruction to the stack;
- write the status word to the stack;
- pulse a clear to the winner's flag, unless that source shares its flag with others;
- clear the status word except one clock-control bit, and issue a vector read;
- hand the fetched vector to the core as its new program counter.

The status word lives in this block. The core can write it directly. A return strobe reloads it with the value popped from the stack. Flags that lost arbitration, or that arrived while the global enable was clear, stay pending. They are taken once the enable comes back.

Top module: `irq_entry_seq`

## Requirements
- R1: A maskable source i is accepted only in a cycle where `boundary_i` is 1, no sequence is running, and `pend_i[i]`, `en_i[i]` and status bit GIE_BIT (default bit 3) are all 1. In any other case `busy_o` stays 0 in the next cycle.
- R2: When `nmi_req_i` and `nmi_en_i` are both 1 at a boundary, the request is accepted whatever the value of GIE. It outranks every maskable source. Because the request is level-sensitive, it is accepted again at the next boundary if it is still asserted.
- R3: Among qualifying maskable sources, the lowest index wins. Sources that lose are not cleared, and they are accepted at a later boundary once the winner's flag is gone.
- R4: In the third sequence cycle, `clr_o` pulses only the winner's bit, and only if that source is single-source. Sources whose bit is set in MULTI_MASK (default: source 2) get no pulse. The NMI gets no pulse. `clr_o` never has more than one bit set.
- R5: In the first sequence cycle, `stk_wdata_o` carries the sampled `pc_i` to address `sp_i`-2. In the second cycle, the status word goes to `sp_i`-4, and `sp_we_o` presents `sp_o` = `sp_i`-4.
- R6: At the end of the fourth cycle, the status word is cleared except bit KEEP_BIT (default bit 6), which keeps its value. GIE is therefore 0.
- R7: In the fourth cycle, `vec_re_o` is 1 with `vec_addr_o` = VEC_BASE - 2*rank. The NMI has rank 0 and maskable source i has rank i+1. In the fifth cycle, `pc_we_o` is 1 with `pc_o` = `vec_data_i`. `busy_o` is 1 for exactly cycles 1 to 5, so the first handler instruction starts 6 cycles after acceptance.
- R8: `sr_we_i` loads `sr_wdata_i` into the status word. `ret_i` loads `ret_sr_i` and wins when both are asserted in the same cycle. A GIE restored this way lets a held pending flag be accepted at the next boundary.
- R9: While reset is asserted, the status word is 0. `busy_o`, `stk_we_o`, `sp_we_o`, `vec_re_o`, `pc_we_o` and `clr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | N_SRC | Per-source pending flags |
| en_i | input | N_SRC | Per-source enables |
| nmi_req_i | input | 1 | Non-maskable request, level-sensitive |
| nmi_en_i | input | 1 | Non-maskable enable |
| boundary_i | input | 1 | Instruction-boundary strobe from the core |
| pc_i | input | W | Address of the next instruction |
| sr_we_i | input | 1 | Core write strobe for the status word |
| sr_wdata_i | input | W | Status word write data |
| ret_i | input | 1 | Return strobe that restores the status word |
| ret_sr_i | input | W | Status word popped by the return |
| sr_o | output | W | Current status word |
| busy_o | output | 1 | Entry sequence running; the core stalls |
| clr_o | output | N_SRC | One-cycle clear pulse for a single-source flag |
| sp_i | input | W | Current stack pointer |
| sp_we_o | output | 1 | Stack pointer update strobe |
| sp_o | output | W | Updated stack pointer |
| stk_we_o | output | 1 | Stack write strobe |
| stk_addr_o | output | W | Stack write address |
| stk_wdata_o | output | W | Stack write data |
| vec_re_o | output | 1 | Vector read strobe |
| vec_addr_o | output | W | Vector table address |
| vec_data_i | input | W | Vector data, valid the cycle after the read |
| pc_we_o | output | 1 | Program counter load strobe |
| pc_o | output | W | New program counter |

## Verification
The bench uses the default build of four maskable sources, with source 2 marked as multi-source, and a 16-bit word. With four sources, every rank from the NMI down to the lowest source can be reached. The mask makes the auto-clear and hold-for-software cases both appear in one run. With VEC_BASE at 16'hFFFE, every vector address lies at the top of the address space, so an error in the address subtraction shows up directly on `vec_addr_o`. Setting both GIE and the preserved bit in the status word shows that only the preserved bit survives entry.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_PC,
    ST_PUSH_SR,
    ST_FLAG,
    ST_STAT,
    ST_LOAD
  } seq_state_e;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_SRC  = 4,
  parameter int RANK_W = 3
) (
  input  logic [N_SRC-1:0]  pend_i,
  input  logic [N_SRC-1:0]  en_i,
  input  logic              gie_i,
  input  logic              nmi_req_i,
  input  logic              nmi_en_i,
  output logic              req_o,
  output logic [RANK_W-1:0] rank_o
);
  logic [N_SRC-1:0] hit;

  assign hit = pend_i & en_i & {N_SRC{gie_i}};

  // rank 0 is the NMI; maskable source i has rank i+1, lowest index wins
  always_comb begin
    req_o  = 1'b0;
    rank_o = '0;
    if (nmi_req_i && nmi_en_i) begin
      req_o = 1'b1;
    end else begin
      for (int i = N_SRC - 1; i >= 0; i--) begin
        if (hit[i]) begin
          req_o  = 1'b1;
          rank_o = RANK_W'(i + 1);
        end
      end
    end
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int W        = 16,
  parameter int KEEP_BIT = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         entry_clr_i,
  input  logic         ret_i,
  input  logic [W-1:0] ret_sr_i,
  input  logic         sw_we_i,
  input  logic [W-1:0] sw_wdata_i,
  output logic [W-1:0] sr_o
);
  localparam logic [W-1:0] KEEP_MASK = W'(1) << KEEP_BIT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sr_o <= '0;
    else if (entry_clr_i) sr_o <= sr_o & KEEP_MASK;
    else if (ret_i)       sr_o <= ret_sr_i;
    else if (sw_we_i)     sr_o <= sw_wdata_i;
  end

  // R8
  ret_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !entry_clr_i) |=> (sr_o == $past(ret_sr_i)));
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_pkg::*;
#(
  parameter int               W          = 16,
  parameter int               N_SRC      = 4,
  parameter int               RANK_W     = 3,
  parameter logic [W-1:0]     VEC_BASE   = 16'hFFFE,
  parameter logic [N_SRC-1:0] MULTI_MASK = 4'b0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boundary_i,
  input  logic              req_i,
  input  logic [RANK_W-1:0] rank_i,
  input  logic [W-1:0]      pc_i,
  input  logic [W-1:0]      sp_i,
  input  logic [W-1:0]      sr_i,
  input  logic [W-1:0]      vec_data_i,
  output logic              busy_o,
  output logic              stk_we_o,
  output logic [W-1:0]      stk_addr_o,
  output logic [W-1:0]      stk_wdata_o,
  output logic              sp_we_o,
  output logic [W-1:0]      sp_o,
  output logic [N_SRC-1:0]  clr_o,
  output logic              sr_clr_o,
  output logic              vec_re_o,
  output logic [W-1:0]      vec_addr_o,
  output logic              pc_we_o,
  output logic [W-1:0]      pc_o
);
  seq_state_e        state_q, state_d;
  logic [RANK_W-1:0] rank_q;
  logic [W-1:0]      pc_q, sp_q;
  logic              go;

  assign go = (state_q == ST_IDLE) && boundary_i && req_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (go) state_d = ST_PUSH_PC;
      ST_PUSH_PC: state_d = ST_PUSH_SR;
      ST_PUSH_SR: state_d = ST_FLAG;
      ST_FLAG:    state_d = ST_STAT;
      ST_STAT:    state_d = ST_LOAD;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rank_q  <= '0;
      pc_q    <= '0;
      sp_q    <= '0;
    end else begin
      state_q <= state_d;
      if (go) begin
        rank_q <= rank_i;
        pc_q   <= pc_i;
        sp_q   <= sp_i;
      end
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign stk_we_o    = (state_q == ST_PUSH_PC) || (state_q == ST_PUSH_SR);
  assign stk_addr_o  = (state_q == ST_PUSH_PC) ? sp_q - W'(2) : sp_q - W'(4);
  assign stk_wdata_o = (state_q == ST_PUSH_PC) ? pc_q : sr_i;
  assign sp_we_o     = (state_q == ST_PUSH_SR);
  assign sp_o        = sp_q - W'(4);
  assign sr_clr_o    = (state_q == ST_STAT);
  assign vec_re_o    = (state_q == ST_STAT);
  assign vec_addr_o  = VEC_BASE - (W'(rank_q) << 1);
  assign pc_we_o     = (state_q == ST_LOAD);
  assign pc_o        = vec_data_i;

  for (genvar g = 0; g < N_SRC; g++) begin : g_clr
    assign clr_o[g] = (state_q == ST_FLAG) && (rank_q == RANK_W'(g + 1)) && !MULTI_MASK[g];
  end

  // R4
  clr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(clr_o));
  // R7
  vec_before_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |-> $past(vec_re_o));
  // R5
  push_descend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stk_we_o && $past(stk_we_o)) |-> (stk_addr_o == $past(stk_addr_o) - W'(2)));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int               W          = 16,
  parameter int               N_SRC      = 4,
  parameter int               GIE_BIT    = 3,
  parameter int               KEEP_BIT   = 6,
  parameter logic [W-1:0]     VEC_BASE   = 16'hFFFE,
  parameter logic [N_SRC-1:0] MULTI_MASK = 4'b0100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             nmi_req_i,
  input  logic             nmi_en_i,
  input  logic             boundary_i,
  input  logic [W-1:0]     pc_i,
  input  logic             sr_we_i,
  input  logic [W-1:0]     sr_wdata_i,
  input  logic             ret_i,
  input  logic [W-1:0]     ret_sr_i,
  output logic [W-1:0]     sr_o,
  output logic             busy_o,
  output logic [N_SRC-1:0] clr_o,
  input  logic [W-1:0]     sp_i,
  output logic             sp_we_o,
  output logic [W-1:0]     sp_o,
  output logic             stk_we_o,
  output logic [W-1:0]     stk_addr_o,
  output logic [W-1:0]     stk_wdata_o,
  output logic             vec_re_o,
  output logic [W-1:0]     vec_addr_o,
  input  logic [W-1:0]     vec_data_i,
  output logic             pc_we_o,
  output logic [W-1:0]     pc_o
);
  localparam int RANK_W = $clog2(N_SRC + 1);

  logic              req;
  logic [RANK_W-1:0] rank;
  logic              sr_clr;

  irq_arbiter #(.N_SRC(N_SRC), .RANK_W(RANK_W)) u_arb (
    .pend_i    (pend_i),
    .en_i      (en_i),
    .gie_i     (sr_o[GIE_BIT]),
    .nmi_req_i (nmi_req_i),
    .nmi_en_i  (nmi_en_i),
    .req_o     (req),
    .rank_o    (rank)
  );

  irq_status_reg #(.W(W), .KEEP_BIT(KEEP_BIT)) u_sr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .entry_clr_i (sr_clr),
    .ret_i       (ret_i),
    .ret_sr_i    (ret_sr_i),
    .sw_we_i     (sr_we_i),
    .sw_wdata_i  (sr_wdata_i),
    .sr_o        (sr_o)
  );

  irq_entry_fsm #(
    .W(W), .N_SRC(N_SRC), .RANK_W(RANK_W), .VEC_BASE(VEC_BASE), .MULTI_MASK(MULTI_MASK)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .boundary_i  (boundary_i),
    .req_i       (req),
    .rank_i      (rank),
    .pc_i        (pc_i),
    .sp_i        (sp_i),
    .sr_i        (sr_o),
    .vec_data_i  (vec_data_i),
    .busy_o      (busy_o),
    .stk_we_o    (stk_we_o),
    .stk_addr_o  (stk_addr_o),
    .stk_wdata_o (stk_wdata_o),
    .sp_we_o     (sp_we_o),
    .sp_o        (sp_o),
    .clr_o       (clr_o),
    .sr_clr_o    (sr_clr),
    .vec_re_o    (vec_re_o),
    .vec_addr_o  (vec_addr_o),
    .pc_we_o     (pc_we_o),
    .pc_o        (pc_o)
  );

  // R1
  gie_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && !$past(nmi_req_i && nmi_en_i)) |-> $past(sr_o[GIE_BIT]));
  // R6
  sr_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(vec_re_o) |-> !sr_o[GIE_BIT]);
  // R6
  keep_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(vec_re_o) |-> (sr_o[KEEP_BIT] == $past(sr_o[KEEP_BIT])));
endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  localparam int W = 16;
  localparam int N = 4;
  localparam logic [N-1:0] MULTI = 4'b0100;
  localparam logic [W-1:0] SP0 = 16'h0400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] pend = '0, en = '0;
  logic nmi_req = 1'b0, nmi_en = 1'b0, boundary = 1'b0;
  logic [W-1:0] pc = '0, sr_wdata = '0, ret_sr = '0, vec_data = '0;
  logic sr_we = 1'b0, ret = 1'b0;
  logic [W-1:0] sr, sp_o, stk_addr, stk_wdata, vec_addr, pc_o;
  logic busy, sp_we, stk_we, vec_re, pc_we;
  logic [N-1:0] clr;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  irq_entry_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .en_i(en),
    .nmi_req_i(nmi_req), .nmi_en_i(nmi_en), .boundary_i(boundary), .pc_i(pc),
    .sr_we_i(sr_we), .sr_wdata_i(sr_wdata), .ret_i(ret), .ret_sr_i(ret_sr),
    .sr_o(sr), .busy_o(busy), .clr_o(clr), .sp_i(SP0), .sp_we_o(sp_we),
    .sp_o(sp_o), .stk_we_o(stk_we), .stk_addr_o(stk_addr), .stk_wdata_o(stk_wdata),
    .vec_re_o(vec_re), .vec_addr_o(vec_addr), .vec_data_i(vec_data),
    .pc_we_o(pc_we), .pc_o(pc_o)
  );

  typedef struct packed {
    logic [15:0] sr;
    logic [3:0]  pend;
    logic [3:0]  en;
    logic        nmi;
    logic        nmi_en;
    logic        acc;
    logic [2:0]  rank;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{16'h0008, 4'b0001, 4'b0001, 1'b0, 1'b0, 1'b1, 3'd1},
    '{16'h0000, 4'b0001, 4'b0001, 1'b0, 1'b0, 1'b0, 3'd0},
    '{16'h0008, 4'b0001, 4'b0000, 1'b0, 1'b0, 1'b0, 3'd0},
    '{16'h0008, 4'b0110, 4'b1111, 1'b0, 1'b0, 1'b1, 3'd2},
    '{16'h0048, 4'b1100, 4'b1111, 1'b0, 1'b0, 1'b1, 3'd3},
    '{16'h0000, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b1, 3'd0},
    '{16'h0008, 4'b1111, 4'b1111, 1'b1, 1'b0, 1'b1, 3'd1},
    '{16'h00F8, 4'b1000, 4'b1000, 1'b0, 1'b0, 1'b1, 3'd4},
    '{16'h0008, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 3'd0},
    '{16'h0008, 4'b1010, 4'b0101, 1'b0, 1'b0, 1'b0, 3'd0}
  };

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_sr(input logic [W-1:0] v);
    sr_we = 1'b1; sr_wdata = v;
    @(negedge clk);
    sr_we = 1'b0;
    chk(sr == v, "R8 sr write", sr, v);
  endtask

  // pulse boundary and follow the entry sequence cycle by cycle
  task automatic run_entry(input bit acc, input logic [2:0] rank, input logic [W-1:0] sr_in,
                           input logic [W-1:0] pcv);
    logic [W-1:0] ea, dat;
    logic [N-1:0] eclr;
    pc = pcv; boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    if (!acc) begin
      chk(busy == 1'b0, "R1 not taken", W'(busy), 16'h0);
      return;
    end
    ea   = 16'hFFFE - (W'(rank) << 1);
    dat  = ea ^ 16'hA5A5;
    eclr = (rank != 0 && !MULTI[rank-1]) ? N'(1) << (rank - 1) : '0;
    chk(busy && stk_we && stk_addr == SP0 - 2 && stk_wdata == pcv, "R5 push pc", stk_wdata, pcv);
    @(negedge clk);
    chk(stk_we && sp_we && stk_addr == SP0 - 4 && sp_o == SP0 - 4 && stk_wdata == sr_in,
        "R5 push sr", stk_wdata, sr_in);
    @(negedge clk);
    chk(clr == eclr, "R4 flag clear", W'(clr), W'(eclr));
    @(negedge clk);
    chk(vec_re && vec_addr == ea, (rank == 0) ? "R2 nmi vector" : "R3 vector", vec_addr, ea);
    vec_data = dat;
    @(negedge clk);
    chk(pc_we && pc_o == dat, "R7 pc load", pc_o, dat);
    chk(sr == (sr_in & 16'h0040), "R6 sr cleared", sr, sr_in & 16'h0040);
    @(negedge clk);
    chk(!busy && !pc_we, "R7 six cycle latency", W'(busy), 16'h0);
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R9 reset state
    chk(sr == '0 && !busy && !stk_we && !sp_we && !vec_re && !pc_we && clr == '0,
        "R9 reset", sr, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      set_sr(TBL[i].sr);
      pend = TBL[i].pend; en = TBL[i].en;
      nmi_req = TBL[i].nmi; nmi_en = TBL[i].nmi_en;
      run_entry(TBL[i].acc, TBL[i].rank, TBL[i].sr, 16'h1230 + W'(i));
      nmi_req = 1'b0; nmi_en = 1'b0;
    end

    // R3 loser held, taken after winner flag cleared by software
    pend = 4'b0011; en = 4'b0011;
    set_sr(16'h0008);
    run_entry(1'b1, 3'd1, 16'h0008, 16'h2000);
    pend = 4'b0010;
    set_sr(16'h0008);
    run_entry(1'b1, 3'd2, 16'h0008, 16'h2002);
    pend = '0; en = '0;

    // R2 level-sensitive NMI nests again with GIE clear
    nmi_req = 1'b1; nmi_en = 1'b1;
    set_sr(16'h0008);
    run_entry(1'b1, 3'd0, 16'h0008, 16'h3000);
    run_entry(1'b1, 3'd0, 16'h0000, 16'h3100);
    nmi_req = 1'b0; nmi_en = 1'b0;

    // R8 flag held with GIE=0, return restores GIE and it is taken
    pend = 4'b0001; en = 4'b0001;
    set_sr(16'h0000);
    run_entry(1'b0, 3'd0, 16'h0000, 16'h4000);
    ret = 1'b1; ret_sr = 16'h0008; sr_we = 1'b1; sr_wdata = 16'h0000;
    @(negedge clk);
    ret = 1'b0; sr_we = 1'b0;
    chk(sr == 16'h0008, "R8 return wins", sr, 16'h0008);
    run_entry(1'b1, 3'd1, 16'h0008, 16'h4002);
    pend = '0; en = '0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule